// File: doc/BRIEF.md
# Price Path Step Iterator

The block advances one simulated asset price by one time step on every clock cycle. Each step applies the update S_next = S * (1 + q + eps * w). Here eps is one Gaussian sample, and q (drift) and w (diffusion) are per-step coefficients that the surrounding logic prepares. The block does no transcendental arithmetic. Each step costs two multiplies and an add chain, and the result feeds straight back into the price register.

A start strobe captures the initial price and the path length, then begins the first path. When the last step of a path is written, the final price appears on the output together with a one-cycle valid pulse. In that same cycle the feedback register is reloaded from the captured initial price. The next path therefore begins with no idle cycle, and paths repeat until another start or a reset. Payoff evaluation and averaging belong to downstream logic.

Top module: `price_path_iter`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `outValid` is 0 and `outPrice` is 0.
- R2: A clock edge with `startIn` high loads `s0In` as the current price. The next clock edge applies the first step to that price.
- R3: Formats are as follows. The price is unsigned with PRICE_FRAC=16 fraction bits in PRICE_W=26 bits. `qIn` and `wIn` are signed two's complement with COEF_FRAC=18 fraction bits in COEF_W=20 bits. `epsIn` is signed with EPS_FRAC=12 fraction bits in EPS_W=16 bits. Each step computes factor = 2^18 + q + floor(eps*w / 2^12) and next = floor(price*factor / 2^18).
- R4: Both scalings in R3 truncate toward minus infinity. No rounding is applied.
- R5: A step whose result exceeds 2^26-1 produces exactly 2^26-1.
- R6: A step whose factor is zero or negative produces price 0.
- R7: With path length N, `outValid` is high for one cycle on each N-th step after start. `outPrice` then holds that step's result and keeps it until the next pulse. With N=1, `outValid` is high on every running cycle.
- R8: After each path ends, the next path starts from the initial price captured at start. Changes on `s0In` during a run have no effect.
- R9: `nStepsIn` is captured at start, and a value of 0 is treated as 1. Changes during a run have no effect.
- R10: A start while a path is running abandons that path with no pulse for it, and begins a new path from the new `s0In`.
- R11: Before the first start after reset, `outValid` stays 0 and `outPrice` stays 0, whatever the coefficient and sample inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Capture the initial price and path length, then begin a path |
| s0In | input | PRICE_W | Initial price, unsigned fixed point |
| nStepsIn | input | STEP_W | Steps per path (0 acts as 1) |
| qIn | input | COEF_W | Drift coefficient for this step, signed |
| wIn | input | COEF_W | Diffusion coefficient for this step, signed |
| epsIn | input | EPS_W | Gaussian sample for this step, signed |
| outValid | output | 1 | One-cycle pulse when a path's final price is written |
| outPrice | output | PRICE_W | Final price of the most recent path |

## Verification
A wrong value in the feedback register has a delayed effect at the ports. A corrupted price or a missed reload is visible only at the next path end, up to N cycles later, as a wrong `outPrice`. The bench therefore compares every pulse against a cycle-level reference and uses short paths, so that a fault shows within a few cycles. A wrong step counter instead shows as a pulse one or more cycles early or late. The bench checks `outValid` on every cycle, so a counter fault is flagged in the first cycle where it differs.

// File: rtl/price_iter_pkg.sv
package price_iter_pkg;
  // strobes passed from sequencing control to the arithmetic datapath
  typedef struct packed {
    logic takeCfg;   // capture initial price
    logic loadStart; // load live initial price into feedback register
    logic step;      // apply one update this cycle
    logic finish;    // this update is the last of the path
  } ctrl_t;
endpackage

// File: rtl/price_iter_ctrl.sv
module price_iter_ctrl
  import price_iter_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic [STEP_W-1:0] nStepsIn,
  output ctrl_t             ctrlStb,
  output logic              outValid
);
  logic              running;
  logic [STEP_W-1:0] stepCnt;
  logic [STEP_W-1:0] lastIdx;
  logic              atLast;

  assign atLast = (stepCnt == lastIdx);

  always_comb begin
    ctrlStb.takeCfg   = startIn;
    ctrlStb.loadStart = startIn;
    ctrlStb.step      = running && !startIn;
    ctrlStb.finish    = running && !startIn && atLast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      stepCnt  <= '0;
      lastIdx  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctrlStb.finish;
      if (startIn) begin
        running <= 1'b1;
        stepCnt <= '0;
        lastIdx <= (nStepsIn == '0) ? '0 : nStepsIn - 1'b1;
      end else if (running) begin
        stepCnt <= atLast ? '0 : stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/price_iter_dp.sv
module price_iter_dp
  import price_iter_pkg::*;
#(
  parameter int PRICE_W   = 26,
  parameter int COEF_W    = 20,
  parameter int COEF_FRAC = 18,
  parameter int EPS_W     = 16,
  parameter int EPS_FRAC  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrl_t                    ctrlStb,
  input  logic        [PRICE_W-1:0] s0In,
  input  logic signed [COEF_W-1:0]  qIn,
  input  logic signed [COEF_W-1:0]  wIn,
  input  logic signed [EPS_W-1:0]   epsIn,
  output logic        [PRICE_W-1:0] priceQ,
  output logic        [PRICE_W-1:0] s0Q,
  output logic        [PRICE_W-1:0] outPrice
);
  localparam int PROD_W = EPS_W + COEF_W;
  localparam int FACT_W = PROD_W + 2;
  localparam int FULL_W = PRICE_W + 1 + FACT_W;
  localparam logic signed [FACT_W-1:0] ONE = FACT_W'(1 << COEF_FRAC);
  localparam logic signed [FULL_W-1:0] MAXP =
    {{(FULL_W-PRICE_W){1'b0}}, {PRICE_W{1'b1}}};

  logic signed [PROD_W-1:0] diffProd;
  logic signed [PROD_W-1:0] diffTerm;
  logic signed [FACT_W-1:0] factor;
  logic signed [FULL_W-1:0] fullProd;
  logic signed [FULL_W-1:0] scaled;
  logic        [PRICE_W-1:0] nextPrice;

  always_comb begin
    diffProd = PROD_W'(epsIn) * PROD_W'(wIn);
    diffTerm = diffProd >>> EPS_FRAC;
    factor   = ONE + FACT_W'(qIn) + FACT_W'(diffTerm);
    fullProd = $signed({1'b0, priceQ}) * factor;
    scaled   = fullProd >>> COEF_FRAC;
    if (scaled < 0)
      nextPrice = '0;
    else if (scaled > MAXP)
      nextPrice = {PRICE_W{1'b1}};
    else
      nextPrice = scaled[PRICE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      priceQ   <= '0;
      s0Q      <= '0;
      outPrice <= '0;
    end else begin
      if (ctrlStb.takeCfg) s0Q <= s0In;
      if (ctrlStb.loadStart) begin
        priceQ <= s0In;
      end else if (ctrlStb.finish) begin
        outPrice <= nextPrice;
        priceQ   <= s0Q;
      end else if (ctrlStb.step) begin
        priceQ <= nextPrice;
      end
    end
  end
endmodule

// File: rtl/price_path_iter.sv
module price_path_iter
  import price_iter_pkg::*;
#(
  parameter int PRICE_W   = 26,
  parameter int COEF_W    = 20,
  parameter int COEF_FRAC = 18,
  parameter int EPS_W     = 16,
  parameter int EPS_FRAC  = 12,
  parameter int STEP_W    = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     startIn,
  input  logic        [PRICE_W-1:0] s0In,
  input  logic        [STEP_W-1:0]  nStepsIn,
  input  logic signed [COEF_W-1:0]  qIn,
  input  logic signed [COEF_W-1:0]  wIn,
  input  logic signed [EPS_W-1:0]   epsIn,
  output logic                     outValid,
  output logic        [PRICE_W-1:0] outPrice
);
  ctrl_t              ctrlStb;
  logic [PRICE_W-1:0] priceQ;
  logic [PRICE_W-1:0] s0Q;

  price_iter_ctrl #(.STEP_W(STEP_W)) ctrl_i (
    .clk(clk), .rst(rst), .startIn(startIn), .nStepsIn(nStepsIn),
    .ctrlStb(ctrlStb), .outValid(outValid)
  );

  price_iter_dp #(
    .PRICE_W(PRICE_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .EPS_W(EPS_W), .EPS_FRAC(EPS_FRAC)
  ) dp_i (
    .clk(clk), .rst(rst), .ctrlStb(ctrlStb), .s0In(s0In),
    .qIn(qIn), .wIn(wIn), .epsIn(epsIn),
    .priceQ(priceQ), .s0Q(s0Q), .outPrice(outPrice)
  );
endmodule

// File: rtl/price_path_iter_chk.sv
module price_path_iter_chk
  import price_iter_pkg::*;
#(
  parameter int PRICE_W = 26
) (
  input logic               clk,
  input logic               rst,
  input logic               startIn,
  input logic [PRICE_W-1:0] s0In,
  input logic               outValid,
  input logic [PRICE_W-1:0] priceQ,
  input logic [PRICE_W-1:0] s0Q,
  input ctrl_t              ctrlStb
);
  logic seenStart;
  always_ff @(posedge clk) begin
    if (rst) seenStart <= 1'b0;
    else if (startIn) seenStart <= 1'b1;
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    startIn |=> priceQ == $past(s0In)); // R2
  AST_NO_PULSE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    startIn |=> !outValid); // R10
  AST_RELOAD_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    ctrlStb.finish |=> priceQ == $past(s0Q)); // R8
  AST_VALID_FOLLOWS_FINISH: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(ctrlStb.finish)); // R7
  AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
    !seenStart |-> !outValid); // R11
endmodule

bind price_path_iter price_path_iter_chk #(.PRICE_W(PRICE_W)) chk_i (
  .clk(clk), .rst(rst), .startIn(startIn), .s0In(s0In), .outValid(outValid),
  .priceQ(priceQ), .s0Q(s0Q), .ctrlStb(ctrlStb)
);

// File: tb/price_path_iter_tb.sv
module price_path_iter_tb_top;
  localparam int PW = 26;
  localparam longint PMAX = (64'd1 << PW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startIn = 1'b0;
  logic [PW-1:0] s0In = '0;
  logic [15:0] nStepsIn = '0;
  logic signed [19:0] qIn = '0;
  logic signed [19:0] wIn = '0;
  logic signed [15:0] epsIn = '0;
  logic outValid;
  logic [PW-1:0] outPrice;

  int errors = 0;
  int checks = 0;

  // reference state
  bit mRun = 0;
  int mCnt = 0, mLen = 1;
  longint mPrice = 0, mS0 = 0, mOutP = 0;
  bit mOutV = 0;

  always #10 clk = ~clk;

  price_path_iter dut_i (
    .clk(clk), .rst(rst), .startIn(startIn), .s0In(s0In), .nStepsIn(nStepsIn),
    .qIn(qIn), .wIn(wIn), .epsIn(epsIn), .outValid(outValid), .outPrice(outPrice)
  );

  // R3/R4/R5/R6 reference arithmetic
  function automatic longint stepRef(longint p, longint q, longint e, longint w);
    longint fac, sc;
    fac = (64'sd1 <<< 18) + q + ((e * w) >>> 12);
    sc = (p * fac) >>> 18;
    if (sc < 0) return 0;
    if (sc > PMAX) return PMAX;
    return sc;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs, advance reference, compare after the edge
  task automatic tick(string tag, bit st, longint s0, int n, longint q, longint e, longint w);
    bit stp, fin;
    longint nx;
    startIn = st; s0In = PW'(s0); nStepsIn = 16'(n);
    qIn = 20'(q); epsIn = 16'(e); wIn = 20'(w);
    stp = mRun && !st;
    fin = stp && (mCnt == mLen - 1);
    nx = stepRef(mPrice, q, e, w);
    mOutV = 0;
    if (st) begin
      mS0 = s0; mPrice = s0; mLen = (n == 0) ? 1 : n; mCnt = 0; mRun = 1;
    end else if (fin) begin
      mOutP = nx; mOutV = 1; mPrice = mS0; mCnt = 0;
    end else if (stp) begin
      mPrice = nx; mCnt++;
    end
    @(negedge clk);
    check({tag, " outValid"}, outValid, mOutV);
    if (mOutV) check({tag, " outPrice"}, outPrice, mOutP);
  endtask

  function automatic longint rs(int span);
    return longint'($urandom_range(2 * span, 0)) - span;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 outValid", outValid, 0);
    check("R1 outPrice", outPrice, 0);
    // R11 coefficients ignored before start
    for (int i = 0; i < 6; i++) tick("R11", 0, 0, 3, rs(5000), rs(8000), rs(5000));
    check("R11 outPrice", outPrice, 0);
    // R2 R9 one-step paths, and zero length acting as one
    tick("R2", 1, 100 << 16, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick("R2", 0, 7, 9, rs(300), rs(8000), 7000);
    tick("R9", 1, 50 << 16, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick("R9", 0, 3, 5, rs(300), rs(8000), 7000);
    // R4 floor on negative diffusion term, exact small case
    tick("R4", 1, 3, 1, 0, 0, 0);
    tick("R4", 0, 3, 1, 0, -1, 1);
    // R5 saturation
    tick("R5", 1, PMAX - 10, 2, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick("R5", 0, 0, 0, 100000, 4000, 5000);
    // R6 non-positive factor
    tick("R6", 1, 200 << 16, 2, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick("R6", 0, 0, 0, -(1 << 18) - 500, 0, 0);
    // R7 R8 R3 random paths, with s0In and nStepsIn disturbed mid run
    for (int p = 0; p < 20; p++) begin
      tick("R7", 1, (longint'($urandom_range(200, 20)) << 16), $urandom_range(12, 3), 0, 0, 0);
      for (int i = 0; i < 40; i++)
        tick("R8", 0, $urandom_range(1 << 24, 0), $urandom_range(20, 0),
             rs(400), rs(12000), $urandom_range(8000, 0));
    end
    // R10 restart mid path abandons it
    tick("R10", 1, 90 << 16, 6, 0, 0, 0);
    for (int i = 0; i < 3; i++) tick("R10", 0, 0, 0, rs(400), rs(12000), 6000);
    tick("R10", 1, 40 << 16, 4, 0, 0, 0);
    for (int i = 0; i < 10; i++) tick("R3", 0, 0, 0, rs(400), rs(12000), 6000);
    // R1 reset mid run
    rst = 1'b1; mRun = 0; mOutV = 0; mOutP = 0; mPrice = 0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 outValid", outValid, 0);
    check("R1 outPrice", outPrice, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule